// File: doc/BRIEF.md
# Atomic Event Mode Controller

This block follows the retry mode of a multi-line atomic event inside one core. An event begins in the optimistic mode, where its accesses run as if nothing were atomic. A failure there moves the controller to a greedy mode. In greedy mode memory ordering is tightened to sequential consistency, and snoops from lower-priority requesters may be refused once decode has reached the event's final locked store. A failure in greedy mode, or a second snoop to a line already snooped during the same event, moves the controller to an arbiter-granted mode. On entry to that mode it asks the system arbiter for exclusive access to the event's lines. The mode changes are never visible to software.

The core reports the lines an event touches on an access strobe. The controller keeps up to `TAG_DEPTH` distinct lines per event, and separately up to `TAG_DEPTH` distinct snooped lines. Both lists are cleared when an event starts. The grant request carries a snapshot of the touched lines. When an arbiter-granted event ends, by success, failure or context switch, a release request carries the same snapshot. A 16-bit signed status word reports the outcome for software to read at a failure point: zero for success, a positive queue position taken from the arbiter's reply, or a negative code for a spurious failure.

Top module: `atomic_mode_ctrl`

## Requirements
- R1: After reset the mode is optimistic (`mode` = 0). `status` is 0, and `seq_cst`, `snp_rsp_valid` and `arb_req_valid` are low. The mode encoding is optimistic = 0, greedy = 1 and arbiter-granted = 2.
- R2: `ev_fail` in optimistic mode makes the mode greedy on the next cycle. `seq_cst` is high exactly while the mode is greedy.
- R3: Every `snp_valid` gets `snp_rsp_valid` on the next cycle. `snp_rsp_nak` is 1 only if, in the snoop cycle, the mode was greedy, `at_lock_store` was high, `snp_prio` < `my_prio` (a smaller number is a lower priority) and the snoop was not a repeat. Otherwise the snoop is accepted.
- R4: In greedy mode, a snoop to a line already snooped since the last `ev_start` is accepted. On the next cycle the mode is arbiter-granted, `status` is -1, and a grant request is issued.
- R5: `ev_fail` in greedy mode makes the mode arbiter-granted on the next cycle. It issues a one-cycle grant request (`arb_req_valid` = 1, `arb_req_release` = 0). Slot i (bits i*ADDR_W upward) of `arb_req_lines` holds the i-th distinct line accessed since `ev_start`, in arrival order. `arb_req_mask` bit i marks slot i as valid. Lines beyond `TAG_DEPTH` are dropped.
- R6: Success, failure or a context switch in arbiter-granted mode returns the mode to optimistic on the next cycle. It also issues a one-cycle release request (`arb_req_release` = 1) with the same lines and mask as the grant.
- R7: `ev_success` in any mode gives optimistic mode and `status` = 0 on the next cycle. `ctx_switch` gives optimistic mode and leaves `status` unchanged.
- R8: `ev_fail` with nonzero `fail_kind` k sets `status` to -k. With `fail_kind` = 0 it leaves `status` unchanged.
- R9: `arb_rsp_valid` in arbiter-granted mode sets `status` to min(`arb_ahead`, 32767). In any other mode it has no effect on `status`.
- R10: `ev_start` empties both line lists, and snoops or accesses in that same cycle are not recorded. Once `TAG_DEPTH` distinct snooped lines are held, further new lines are not recorded, so a repeat of such a line does not count as a repeat.
- R11: Strobes in one cycle resolve in this order: `ctx_switch`, then `ev_success`, then `ev_fail`, then a repeated snoop, then `arb_rsp_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_start | input | 1 | An atomic event begins |
| ev_success | input | 1 | The event completed successfully |
| ev_fail | input | 1 | The event failed |
| fail_kind | input | KIND_W | Spurious-failure code for `ev_fail`, 0 for none |
| ctx_switch | input | 1 | Context switch |
| acc_valid | input | 1 | The event touches a line |
| acc_line | input | ADDR_W | Line address touched |
| snp_valid | input | 1 | Incoming snoop |
| snp_line | input | ADDR_W | Snooped line address |
| snp_prio | input | PRIO_W | Requester priority of the snoop |
| my_prio | input | PRIO_W | This core's priority |
| at_lock_store | input | 1 | Decode has reached the final locked store |
| arb_rsp_valid | input | 1 | Arbiter reply to a grant |
| arb_ahead | input | 16 | Number of events queued ahead |
| mode | output | 2 | Current mode |
| seq_cst | output | 1 | Force sequential consistency in the load/store unit |
| snp_rsp_valid | output | 1 | Snoop response valid |
| snp_rsp_nak | output | 1 | Snoop refused (1) or accepted (0) |
| arb_req_valid | output | 1 | Request to the arbiter |
| arb_req_release | output | 1 | 1 = release, 0 = grant |
| arb_req_lines | output | TAG_DEPTH*ADDR_W | Line set, slot i at bits i*ADDR_W upward |
| arb_req_mask | output | TAG_DEPTH | Valid slots of the line set |
| status | output | 16 | Signed outcome word |

## Verification
The refusal rule is swept over every pair of snoop and core priority, with the lock-store flag both ways, in the optimistic and greedy modes. This separates the greedy-only gate, the lock-store gate and the strict priority comparison. Access sequences with duplicates and more lines than the list holds show the dedup, the arrival order and the dropping of extra lines in the grant. A later event that touches other lines shows that the release reuses the grant snapshot. Sweeps of failure codes and queue counts around the 32767 limit check the status arithmetic. Simultaneous strobes and a full snoop list check the priority order and the point at which repeat detection stops.

// File: rtl/aem_pkg.sv
package aem_pkg;

  typedef enum logic [1:0] {
    MODE_OPT    = 2'd0,
    MODE_GREEDY = 2'd1,
    MODE_METH   = 2'd2
  } aem_mode_e;

  localparam int STAT_W = 16;

  // status code written when a repeated snoop ends a greedy event
  localparam logic [STAT_W-1:0] ST_SNOOP_REPEAT = 16'hFFFF;

  // two's-complement negation of a failure code
  function automatic logic [STAT_W-1:0] neg_code(input logic [STAT_W-1:0] k);
    return STAT_W'(~k + 16'd1);
  endfunction

  // queue count clipped to the largest positive status value
  function automatic logic [STAT_W-1:0] sat_ahead(input logic [STAT_W-1:0] a);
    return a[STAT_W-1] ? 16'h7FFF : a;
  endfunction

endpackage

// File: rtl/aem_line_table.sv
module aem_line_table #(
  parameter int W     = 32,
  parameter int DEPTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             ins,
  input  logic [W-1:0]     line,
  output logic             hit,
  output logic             full,
  output logic [DEPTH*W-1:0] entries,
  output logic [DEPTH-1:0] mask
);
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [CNT_W-1:0] cnt_q;
  logic [DEPTH-1:0] vld_q;
  logic [DEPTH-1:0] match;
  logic             ins_ok;

  assign full   = (cnt_q == CNT_W'(DEPTH));
  assign hit    = |match;
  assign ins_ok = ins && !clr && !hit && !full;
  assign mask   = vld_q;

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    logic [W-1:0] ent_q;
    assign match[i] = vld_q[i] && (ent_q == line);
    assign entries[i*W +: W] = ent_q;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        ent_q    <= '0;
        vld_q[i] <= 1'b0;
      end else if (clr) begin
        vld_q[i] <= 1'b0;
      end else if (ins_ok && cnt_q == CNT_W'(i)) begin
        ent_q    <= line;
        vld_q[i] <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      cnt_q <= '0;
    else if (clr)    cnt_q <= '0;
    else if (ins_ok) cnt_q <= cnt_q + 1'b1;
  end

endmodule

// File: rtl/aem_snoop_judge.sv
module aem_snoop_judge
  import aem_pkg::*;
#(
  parameter int PRIO_W = 4
) (
  input  aem_mode_e         mode,
  input  logic              snp_valid,
  input  logic              snp_seen,
  input  logic              at_lock_store,
  input  logic [PRIO_W-1:0] snp_prio,
  input  logic [PRIO_W-1:0] my_prio,
  output logic              nak_now,
  output logic              repeat_now
);
  // smaller number means lower priority
  function automatic logic prio_below(input logic [PRIO_W-1:0] them,
                                      input logic [PRIO_W-1:0] us);
    return them < us;
  endfunction

  logic in_greedy;
  assign in_greedy  = (mode == MODE_GREEDY);
  assign repeat_now = snp_valid && in_greedy && snp_seen;
  assign nak_now    = snp_valid && in_greedy && at_lock_store && !snp_seen
                      && prio_below(snp_prio, my_prio);

endmodule

// File: rtl/aem_mode_fsm.sv
module aem_mode_fsm
  import aem_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int TAG_DEPTH = 8,
  parameter int KIND_W    = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        ev_success,
  input  logic                        ev_fail,
  input  logic [KIND_W-1:0]           fail_kind,
  input  logic                        ctx_switch,
  input  logic                        repeat_now,
  input  logic                        arb_rsp_valid,
  input  logic [STAT_W-1:0]           arb_ahead,
  input  logic [TAG_DEPTH*ADDR_W-1:0] set_lines,
  input  logic [TAG_DEPTH-1:0]        set_mask,
  output aem_mode_e                   mode_q,
  output logic [STAT_W-1:0]           status_q,
  output logic                        grant_fire,
  output logic                        release_fire,
  output logic                        req_valid_q,
  output logic                        req_release_q,
  output logic [TAG_DEPTH*ADDR_W-1:0] snap_lines_q,
  output logic [TAG_DEPTH-1:0]        snap_mask_q
);
  aem_mode_e         mode_d;
  logic [STAT_W-1:0] status_d;
  logic              in_meth;

  assign in_meth = (mode_q == MODE_METH);

  always_comb begin
    mode_d       = mode_q;
    grant_fire   = 1'b0;
    release_fire = 1'b0;
    if (ctx_switch || ev_success) begin
      mode_d       = MODE_OPT;
      release_fire = in_meth;
    end else if (ev_fail) begin
      unique case (mode_q)
        MODE_OPT:    mode_d = MODE_GREEDY;
        MODE_GREEDY: begin
          mode_d     = MODE_METH;
          grant_fire = 1'b1;
        end
        default: begin
          mode_d       = MODE_OPT;
          release_fire = 1'b1;
        end
      endcase
    end else if (repeat_now) begin
      mode_d     = MODE_METH;
      grant_fire = 1'b1;
    end
  end

  always_comb begin
    status_d = status_q;
    if (ctx_switch) begin
      status_d = status_q;
    end else if (ev_success) begin
      status_d = '0;
    end else if (ev_fail) begin
      if (fail_kind != '0) status_d = neg_code(STAT_W'(fail_kind));
    end else if (repeat_now) begin
      status_d = ST_SNOOP_REPEAT;
    end else if (arb_rsp_valid && in_meth) begin
      status_d = sat_ahead(arb_ahead);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q        <= MODE_OPT;
      status_q      <= '0;
      req_valid_q   <= 1'b0;
      req_release_q <= 1'b0;
      snap_lines_q  <= '0;
      snap_mask_q   <= '0;
    end else begin
      mode_q        <= mode_d;
      status_q      <= status_d;
      req_valid_q   <= grant_fire || release_fire;
      req_release_q <= release_fire;
      if (grant_fire) begin
        snap_lines_q <= set_lines;
        snap_mask_q  <= set_mask;
      end
    end
  end

endmodule

// File: rtl/atomic_mode_ctrl.sv
module atomic_mode_ctrl
  import aem_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int PRIO_W    = 4,
  parameter int TAG_DEPTH = 8,
  parameter int KIND_W    = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        ev_start,
  input  logic                        ev_success,
  input  logic                        ev_fail,
  input  logic [KIND_W-1:0]           fail_kind,
  input  logic                        ctx_switch,
  input  logic                        acc_valid,
  input  logic [ADDR_W-1:0]           acc_line,
  input  logic                        snp_valid,
  input  logic [ADDR_W-1:0]           snp_line,
  input  logic [PRIO_W-1:0]           snp_prio,
  input  logic [PRIO_W-1:0]           my_prio,
  input  logic                        at_lock_store,
  input  logic                        arb_rsp_valid,
  input  logic [15:0]                 arb_ahead,
  output logic [1:0]                  mode,
  output logic                        seq_cst,
  output logic                        snp_rsp_valid,
  output logic                        snp_rsp_nak,
  output logic                        arb_req_valid,
  output logic                        arb_req_release,
  output logic [TAG_DEPTH*ADDR_W-1:0] arb_req_lines,
  output logic [TAG_DEPTH-1:0]        arb_req_mask,
  output logic [15:0]                 status
);
  aem_mode_e                   mode_q;
  logic                        snp_hit, snp_seen, nak_now, repeat_now;
  logic                        grant_fire, release_fire;
  logic                        acc_hit_unused, acc_full_unused, snp_full_unused;
  logic [TAG_DEPTH*ADDR_W-1:0] set_lines, snp_lines_unused;
  logic [TAG_DEPTH-1:0]        set_mask, snp_mask_unused;
  logic                        rsp_valid_q, rsp_nak_q;

  // lines touched by the current event
  aem_line_table #(.W(ADDR_W), .DEPTH(TAG_DEPTH)) u_acc_tbl (
    .clk(clk), .rst_n(rst_n), .clr(ev_start), .ins(acc_valid), .line(acc_line),
    .hit(acc_hit_unused), .full(acc_full_unused),
    .entries(set_lines), .mask(set_mask)
  );

  // lines snooped during the current event
  aem_line_table #(.W(ADDR_W), .DEPTH(TAG_DEPTH)) u_snp_tbl (
    .clk(clk), .rst_n(rst_n), .clr(ev_start), .ins(snp_valid), .line(snp_line),
    .hit(snp_hit), .full(snp_full_unused),
    .entries(snp_lines_unused), .mask(snp_mask_unused)
  );

  assign snp_seen = snp_hit && !ev_start;

  aem_snoop_judge #(.PRIO_W(PRIO_W)) u_judge (
    .mode(mode_q), .snp_valid(snp_valid), .snp_seen(snp_seen),
    .at_lock_store(at_lock_store), .snp_prio(snp_prio), .my_prio(my_prio),
    .nak_now(nak_now), .repeat_now(repeat_now)
  );

  aem_mode_fsm #(.ADDR_W(ADDR_W), .TAG_DEPTH(TAG_DEPTH), .KIND_W(KIND_W)) u_fsm (
    .clk(clk), .rst_n(rst_n),
    .ev_success(ev_success), .ev_fail(ev_fail), .fail_kind(fail_kind),
    .ctx_switch(ctx_switch), .repeat_now(repeat_now),
    .arb_rsp_valid(arb_rsp_valid), .arb_ahead(arb_ahead),
    .set_lines(set_lines), .set_mask(set_mask),
    .mode_q(mode_q), .status_q(status),
    .grant_fire(grant_fire), .release_fire(release_fire),
    .req_valid_q(arb_req_valid), .req_release_q(arb_req_release),
    .snap_lines_q(arb_req_lines), .snap_mask_q(arb_req_mask)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid_q <= 1'b0;
      rsp_nak_q   <= 1'b0;
    end else begin
      rsp_valid_q <= snp_valid;
      rsp_nak_q   <= nak_now;
    end
  end

  assign snp_rsp_valid = rsp_valid_q;
  assign snp_rsp_nak   = rsp_nak_q;
  assign mode          = mode_q;
  assign seq_cst       = (mode_q == MODE_GREEDY);

endmodule

// File: rtl/aem_checker.sv
module aem_checker
  import aem_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int PRIO_W    = 4,
  parameter int TAG_DEPTH = 8
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic [1:0]                  mode,
  input logic                        ev_success,
  input logic                        ev_fail,
  input logic                        ctx_switch,
  input logic                        at_lock_store,
  input logic [PRIO_W-1:0]           snp_prio,
  input logic [PRIO_W-1:0]           my_prio,
  input logic                        snp_rsp_valid,
  input logic                        snp_rsp_nak,
  input logic                        repeat_now,
  input logic                        arb_req_valid,
  input logic                        arb_req_release,
  input logic [TAG_DEPTH*ADDR_W-1:0] arb_req_lines,
  input logic [TAG_DEPTH-1:0]        arb_req_mask,
  input logic [15:0]                 status
);

  a_r1_legal_mode: assert property (@(posedge clk) disable iff (!rst_n)
    mode != 2'd3);

  a_r2_fail_opt_greedy: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_OPT && ev_fail && !ev_success && !ctx_switch) |=> mode == MODE_GREEDY);

  a_r3_nak_conditions: assert property (@(posedge clk) disable iff (!rst_n)
    (snp_rsp_valid && snp_rsp_nak) |->
      ($past(mode) == MODE_GREEDY && $past(at_lock_store) && $past(snp_prio) < $past(my_prio)));

  a_r4_repeat_grants: assert property (@(posedge clk) disable iff (!rst_n)
    (repeat_now && !ev_fail && !ev_success && !ctx_switch) |=>
      (mode == MODE_METH && arb_req_valid && !arb_req_release && status == 16'hFFFF));

  a_r5_grant_in_meth: assert property (@(posedge clk) disable iff (!rst_n)
    (arb_req_valid && !arb_req_release) |-> mode == MODE_METH);

  a_r6_release_same_set: assert property (@(posedge clk) disable iff (!rst_n)
    (arb_req_valid && arb_req_release) |->
      ($stable(arb_req_lines) && $stable(arb_req_mask) && mode == MODE_OPT));

  a_r7_success_opt: assert property (@(posedge clk) disable iff (!rst_n)
    ev_success |=> (mode == MODE_OPT && status == 16'd0));

  a_r7_ctx_opt: assert property (@(posedge clk) disable iff (!rst_n)
    ctx_switch |=> (mode == MODE_OPT && $stable(status)));

endmodule

bind atomic_mode_ctrl aem_checker #(
  .ADDR_W(ADDR_W), .PRIO_W(PRIO_W), .TAG_DEPTH(TAG_DEPTH)
) u_chk (
  .clk(clk), .rst_n(rst_n), .mode(mode), .ev_success(ev_success),
  .ev_fail(ev_fail), .ctx_switch(ctx_switch), .at_lock_store(at_lock_store),
  .snp_prio(snp_prio), .my_prio(my_prio), .snp_rsp_valid(snp_rsp_valid),
  .snp_rsp_nak(snp_rsp_nak), .repeat_now(repeat_now),
  .arb_req_valid(arb_req_valid), .arb_req_release(arb_req_release),
  .arb_req_lines(arb_req_lines), .arb_req_mask(arb_req_mask), .status(status)
);

// File: tb/tb_atomic_mode_ctrl.sv
module tb_atomic_mode_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 12;
  localparam int PW = 3;
  localparam int TD = 4;
  localparam int KW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ev_start = 0, ev_success = 0, ev_fail = 0, ctx_switch = 0;
  logic [KW-1:0] fail_kind = '0;
  logic acc_valid = 0, snp_valid = 0, at_lock_store = 0, arb_rsp_valid = 0;
  logic [AW-1:0] acc_line = '0, snp_line = '0;
  logic [PW-1:0] snp_prio = '0, my_prio = '0;
  logic [15:0] arb_ahead = '0;
  logic [1:0] mode;
  logic seq_cst, snp_rsp_valid, snp_rsp_nak, arb_req_valid, arb_req_release;
  logic [TD*AW-1:0] arb_req_lines;
  logic [TD-1:0] arb_req_mask;
  logic [15:0] status;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  atomic_mode_ctrl #(.ADDR_W(AW), .PRIO_W(PW), .TAG_DEPTH(TD), .KIND_W(KW)) dut (
    .clk(clk), .rst_n(rst_n), .ev_start(ev_start), .ev_success(ev_success),
    .ev_fail(ev_fail), .fail_kind(fail_kind), .ctx_switch(ctx_switch),
    .acc_valid(acc_valid), .acc_line(acc_line), .snp_valid(snp_valid),
    .snp_line(snp_line), .snp_prio(snp_prio), .my_prio(my_prio),
    .at_lock_store(at_lock_store), .arb_rsp_valid(arb_rsp_valid),
    .arb_ahead(arb_ahead), .mode(mode), .seq_cst(seq_cst),
    .snp_rsp_valid(snp_rsp_valid), .snp_rsp_nak(snp_rsp_nak),
    .arb_req_valid(arb_req_valid), .arb_req_release(arb_req_release),
    .arb_req_lines(arb_req_lines), .arb_req_mask(arb_req_mask), .status(status)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  function automatic int sval();
    return int'($signed(status));
  endfunction

  task automatic tick();
    @(posedge clk);
    #1;
    ev_start = 0; ev_success = 0; ev_fail = 0; ctx_switch = 0; fail_kind = '0;
    acc_valid = 0; snp_valid = 0; arb_rsp_valid = 0;
  endtask

  task automatic do_fail(input int k);
    ev_fail = 1; fail_kind = KW'(k); tick();
  endtask

  task automatic do_snoop(input int line, input int sp, input int mp, input bit ls);
    snp_valid = 1; snp_line = AW'(line); snp_prio = PW'(sp); my_prio = PW'(mp);
    at_lock_store = ls; tick();
  endtask

  task automatic to_opt();
    ctx_switch = 1; tick();
  endtask

  // expected dedup of an access sequence
  logic [AW-1:0] acc_seq [8];
  logic [AW-1:0] exp_lines [TD];
  int exp_n;

  task automatic run_access(input int n);
    exp_n = 0;
    for (int i = 0; i < n; i++) begin
      bit dup = 0;
      for (int j = 0; j < exp_n; j++) if (exp_lines[j] == acc_seq[i]) dup = 1;
      if (!dup && exp_n < TD) begin
        exp_lines[exp_n] = acc_seq[i];
        exp_n++;
      end
      acc_valid = 1; acc_line = acc_seq[i]; tick();
    end
  endtask

  task automatic chk_set(input string req);
    chk(req, int'(arb_req_mask), (1 << exp_n) - 1);
    for (int j = 0; j < exp_n; j++)
      chk(req, int'(arb_req_lines[j*AW +: AW]), int'(exp_lines[j]));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int ln;
    tick(); tick();
    rst_n = 1;
    // R1 reset state
    chk("R1 mode", int'(mode), 0);
    chk("R1 status", sval(), 0);
    chk("R1 seq", int'(seq_cst), 0);
    chk("R1 rsp", int'(snp_rsp_valid), 0);
    chk("R1 req", int'(arb_req_valid), 0);

    // R2 optimistic failure escalates
    do_fail(0);
    chk("R2 mode", int'(mode), 1);
    chk("R2 seq", int'(seq_cst), 1);
    chk("R8 kind0 keeps", sval(), 0);
    ev_success = 1; tick();
    chk("R7 success mode", int'(mode), 0);
    chk("R2 seq off", int'(seq_cst), 0);

    // R3 refusal sweep
    ln = 1;
    for (int md = 0; md < 2; md++) begin
      to_opt();
      if (md == 1) do_fail(0);
      for (int ls = 0; ls < 2; ls++)
        for (int sp = 0; sp < 8; sp++)
          for (int mp = 0; mp < 8; mp++) begin
            ev_start = 1; tick();
            do_snoop(ln, sp, mp, ls[0]);
            ln++;
            chk("R3 rsp valid", int'(snp_rsp_valid), 1);
            chk("R3 nak", int'(snp_rsp_nak), int'(md == 1 && ls == 1 && sp < mp));
            chk("R3 mode kept", int'(mode), md);
          end
    end

    // R4 repeated snoop in greedy
    to_opt(); do_fail(0);
    ev_start = 1; tick();
    do_snoop(700, 0, 7, 1);
    chk("R4 first nak", int'(snp_rsp_nak), 1);
    do_snoop(700, 0, 7, 1);
    chk("R4 accept", int'(snp_rsp_nak), 0);
    chk("R4 mode", int'(mode), 2);
    chk("R4 status", sval(), -1);
    chk("R4 grant", int'(arb_req_valid), 1);
    chk("R4 grant kind", int'(arb_req_release), 0);
    tick();
    chk("R4 pulse", int'(arb_req_valid), 0);
    ev_success = 1; tick();
    chk("R6 release", int'(arb_req_valid && arb_req_release), 1);
    chk("R7 status", sval(), 0);

    // R5 and R6 line set with duplicates and overflow
    ev_start = 1; tick();
    acc_seq = '{12'd5, 12'd7, 12'd5, 12'd9, 12'd11, 12'd7, 12'd13, 12'd15};
    run_access(8);
    do_fail(0);
    do_fail(0);
    chk("R5 mode", int'(mode), 2);
    chk("R5 grant", int'(arb_req_valid && !arb_req_release), 1);
    chk_set("R5 set");
    ev_start = 1; tick();
    acc_valid = 1; acc_line = 12'd100; tick();
    do_fail(3);
    chk("R6 mode", int'(mode), 0);
    chk("R6 release", int'(arb_req_valid && arb_req_release), 1);
    chk_set("R6 set");
    chk("R8 status", sval(), -3);

    // R5 partial set, R6 release on context switch
    ev_start = 1; tick();
    acc_seq = '{12'd40, 12'd41, 12'd40, 12'd41, 12'd0, 12'd0, 12'd0, 12'd0};
    run_access(4);
    do_fail(0); do_fail(0);
    chk_set("R5 partial");

    // R9 arbiter counts
    begin
      int av[8] = '{0, 1, 2, 100, 32767, 32768, 40000, 65535};
      for (int i = 0; i < 8; i++) begin
        arb_rsp_valid = 1; arb_ahead = 16'(av[i]); tick();
        chk("R9 status", sval(), (av[i] > 32767) ? 32767 : av[i]);
      end
    end
    to_opt();
    chk("R6 ctx release", int'(arb_req_valid && arb_req_release), 1);
    chk("R7 ctx status", sval(), 32767);
    arb_rsp_valid = 1; arb_ahead = 16'd5; tick();
    chk("R9 ignored", sval(), 32767);

    // R8 failure code sweep
    for (int k = 1; k < 16; k++) begin
      do_fail(k);
      chk("R8 code", sval(), -k);
    end
    do_fail(0);
    chk("R8 kind0", sval(), -15);

    // R10 clearing and full snoop list
    to_opt(); do_fail(0);
    ev_start = 1; tick();
    for (int i = 0; i < TD; i++) do_snoop(200 + i, 0, 0, 0);
    do_snoop(300, 0, 0, 0);
    do_snoop(300, 0, 0, 0);
    chk("R10 full no repeat", int'(mode), 1);
    ev_start = 1; snp_valid = 1; snp_line = 12'd400; tick();
    do_snoop(400, 0, 0, 0);
    chk("R10 start snoop unrecorded", int'(mode), 1);
    ev_start = 1; tick();
    do_snoop(200, 0, 0, 0);
    chk("R10 cleared", int'(mode), 1);
    do_snoop(200, 0, 0, 0);
    chk("R10 repeat after clear", int'(mode), 2);

    // R11 simultaneous strobes
    to_opt(); do_fail(0);
    ev_fail = 1; ctx_switch = 1; tick();
    chk("R11 ctx over fail", int'(mode), 0);
    chk("R11 no grant", int'(arb_req_valid), 0);
    do_fail(0);
    ev_start = 1; tick();
    do_snoop(500, 0, 0, 0);
    snp_valid = 1; snp_line = 12'd500; ev_fail = 1; fail_kind = 4'd5; tick();
    chk("R11 fail over repeat", sval(), -5);
    chk("R11 meth", int'(mode), 2);
    ev_success = 1; ev_fail = 1; fail_kind = 4'd2; arb_rsp_valid = 1; arb_ahead = 16'd9; tick();
    chk("R11 success over fail", sval(), 0);
    chk("R11 mode", int'(mode), 0);
    chk("R11 release", int'(arb_req_valid && arb_req_release), 1);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule